// File: doc/BRIEF.md
# XON/XOFF Transmit Flow Generator

This block sits beside a UART transmitter and handles the sending side of in-band software flow control. It compares the receive FIFO fill level against two programmable thresholds. When the FIFO is getting too full, it asks the far end to stop sending by injecting stop characters into the outgoing character stream. When the FIFO has drained far enough, it asks the far end to start again by injecting resume characters. The two thresholds are separate, so there is a hysteresis band between them.

Each threshold is a 4-bit field. The value is multiplied by four to give a count of FIFO entries. A 2-bit mode field selects which of the two programmed stop/resume character sets is used, or both sets in order. Every request is sent twice. The block keeps a paused flag that shows whether the remote sender has been told to stop. If flow control is switched off while the remote is paused, the block still sends the resume characters, so the link cannot stay stalled.

Flow characters are offered to the serializer through a valid/ready handshake. While a flow sequence is pending, a stall output holds off the TX FIFO read path, so flow characters win at the next character boundary and never interrupt a character already being sent. Characters are trimmed to the programmed word length.

The sequencer has four states and six transitions:
- RUN → HALT_TX when flow control is on and the level is above the halt threshold.
- HALT_TX loops on each accepted character, and moves to PAUSED after the last one.
- PAUSED → RESUME_TX when flow control is turned off, or when the level is at or below the resume threshold.
- RESUME_TX loops on each accepted character, and moves to RUN after the last one.

Top module: `xonxoff_tx_gen`

## Requirements
- R1: After reset, `char_valid`, `fifo_stall` and `flow_paused` are all 0.
- R2: In RUN with `tx_mode` ≠ 0, a level strictly greater than `halt_trig`×4 starts the stop sequence. When its last character has been accepted, `flow_paused` becomes 1.
- R3: In PAUSED, a level less than or equal to `resume_trig`×4 starts the resume sequence. When its last character has been accepted, `flow_paused` returns to 0.
- R4: With `tx_mode`=2'b10, each sequence is character set 1 (`xon1`/`xoff1`) sent twice. With `tx_mode`=2'b01, it is set 2 (`xon2`/`xoff2`) sent twice.
- R5: With `tx_mode`=2'b11, each sequence is four characters in the order set 1, set 2, set 1, set 2.
- R6: In RUN with `tx_mode`=2'b00, no character is ever offered, whatever the level.
- R7: If `tx_mode` becomes 2'b00 while PAUSED, the resume sequence for the mode latched at pause time is still sent, and the block returns to RUN.
- R8: Each offered character is masked to the word length. `word_len` 2'b00/01/10/11 keeps the low 5/6/7/8 bits, and the upper bits are 0.
- R9: While `char_valid` is high and `char_ready` is low, `char_valid` stays high and `char_data` stays stable. Each cycle with both high transfers exactly one character.
- R10: `fifo_stall` is high whenever a flow character is being offered.
- R11: Levels inside the hysteresis band have no effect: a level equal to `halt_trig`×4 does not start a stop sequence, and in PAUSED a level above `resume_trig`×4 does not start a resume sequence.
- R12: The mode is latched when a stop sequence starts. Changing `tx_mode` to another nonzero value partway through a sequence does not change the characters that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_level | input | LVL_W | Current receive FIFO fill count |
| halt_trig | input | TRIG_W | Stop threshold, in units of four entries |
| resume_trig | input | TRIG_W | Resume threshold, in units of four entries |
| tx_mode | input | 2 | Transmit flow mode (00 off, 10 set 1, 01 set 2, 11 both) |
| xon1 | input | CHAR_W | Resume character, set 1 |
| xon2 | input | CHAR_W | Resume character, set 2 |
| xoff1 | input | CHAR_W | Stop character, set 1 |
| xoff2 | input | CHAR_W | Stop character, set 2 |
| word_len | input | 2 | Word length select (5/6/7/8 bits) |
| char_ready | input | 1 | Serializer accepts a character at a boundary |
| char_valid | output | 1 | A flow character is offered |
| char_data | output | CHAR_W | Offered flow character, masked to word length |
| fifo_stall | output | 1 | Holds off TX FIFO reads while flow characters are pending |
| flow_paused | output | 1 | Remote sender has been told to stop |

## Verification
The bench targets the threshold edges:
- A level exactly at the halt value must not start a stop sequence. A design that compares with ≥ would pause one entry too early.
- A level one above the resume value must not resume. A design that checks only one threshold would oscillate inside the band.

It also covers these cases:
- Disabling flow control while paused must still produce the resume characters. A design that gates the whole machine on the mode would leave the remote stalled forever.
- Pair-mode ordering is checked. A swapped index decode would reverse the characters.
- Changing the mode partway through a sequence is checked. A design without a latched mode would mix character sets.
- Serializer back-pressure is checked. A design that advances without the handshake would drop characters or change data while it is unaccepted.

// File: rtl/xf_pkg.sv
package xf_pkg;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_HALT_TX   = 2'd1,
        ST_PAUSED    = 2'd2,
        ST_RESUME_TX = 2'd3
    } xf_state_e;

    localparam logic [1:0] MODE_OFF  = 2'b00;
    localparam logic [1:0] MODE_SET2 = 2'b01;
    localparam logic [1:0] MODE_SET1 = 2'b10;
    localparam logic [1:0] MODE_BOTH = 2'b11;

    // Index of the last character in a sequence for a given mode.
    function automatic logic [1:0] seq_last(input logic [1:0] mode);
        return (mode == MODE_BOTH) ? 2'd3 : 2'd1;
    endfunction

endpackage

// File: rtl/xf_trigger.sv
module xf_trigger #(
    parameter int LVL_W   = 7,
    parameter int TRIG_W  = 4,
    parameter int SCALE_SH = 2
) (
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [TRIG_W-1:0] halt_trig,
    input  logic [TRIG_W-1:0] resume_trig,
    output logic              over_halt,
    output logic              at_resume
);
    localparam int TW = TRIG_W + SCALE_SH;
    localparam int CW = (LVL_W > TW) ? LVL_W : TW;

    logic [CW-1:0] lvl_x;
    logic [CW-1:0] halt_x;
    logic [CW-1:0] resume_x;

    always_comb begin
        lvl_x    = CW'(fifo_level);
        halt_x   = CW'(halt_trig) << SCALE_SH;
        resume_x = CW'(resume_trig) << SCALE_SH;
        over_halt = (lvl_x > halt_x);
        at_resume = (lvl_x <= resume_x);
    end
endmodule

// File: rtl/xf_char_pick.sv
module xf_char_pick #(
    parameter int CHAR_W = 8,
    parameter int MIN_W  = 5
) (
    input  logic [1:0]        seq_mode,
    input  logic              send_xon,
    input  logic [1:0]        idx,
    input  logic [1:0]        word_len,
    input  logic [CHAR_W-1:0] xon1,
    input  logic [CHAR_W-1:0] xon2,
    input  logic [CHAR_W-1:0] xoff1,
    input  logic [CHAR_W-1:0] xoff2,
    output logic [CHAR_W-1:0] char_data
);
    import xf_pkg::*;

    logic              use_set2;
    logic [CHAR_W-1:0] raw;
    logic [CHAR_W-1:0] keep;

    always_comb begin
        unique case (seq_mode)
            MODE_SET2: use_set2 = 1'b1;
            MODE_BOTH: use_set2 = idx[0];
            default:   use_set2 = 1'b0;
        endcase
        if (send_xon) raw = use_set2 ? xon2 : xon1;
        else          raw = use_set2 ? xoff2 : xoff1;
    end

    genvar b;
    generate
        for (b = 0; b < CHAR_W; b++) begin : g_mask
            if (b < MIN_W) begin : g_fixed
                assign keep[b] = 1'b1;
            end else begin : g_var
                assign keep[b] = (int'(word_len) >= (b - MIN_W + 1));
            end
        end
    endgenerate

    assign char_data = raw & keep;
endmodule

// File: rtl/xf_seq_fsm.sv
module xf_seq_fsm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] tx_mode,
    input  logic       over_halt,
    input  logic       at_resume,
    input  logic       char_ready,
    output logic       char_valid,
    output logic       send_xon,
    output logic [1:0] idx,
    output logic [1:0] seq_mode,
    output logic       fifo_stall,
    output logic       flow_paused
);
    import xf_pkg::*;

    xf_state_e state, state_nxt;
    logic [1:0] idx_nxt;
    logic [1:0] mode_nxt;
    logic       accept;

    assign accept = char_valid && char_ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            idx      <= 2'd0;
            seq_mode <= MODE_OFF;
        end else begin
            state    <= state_nxt;
            idx      <= idx_nxt;
            seq_mode <= mode_nxt;
        end
    end

    // Next state
    always_comb begin
        state_nxt = state;
        idx_nxt   = idx;
        mode_nxt  = seq_mode;
        unique case (state)
            ST_RUN: begin
                if (tx_mode != MODE_OFF && over_halt) begin
                    state_nxt = ST_HALT_TX;
                    idx_nxt   = 2'd0;
                    mode_nxt  = tx_mode;
                end
            end
            ST_HALT_TX: begin
                if (accept) begin
                    if (idx == seq_last(seq_mode)) state_nxt = ST_PAUSED;
                    else                           idx_nxt   = idx + 2'd1;
                end
            end
            ST_PAUSED: begin
                if (tx_mode == MODE_OFF || at_resume) begin
                    state_nxt = ST_RESUME_TX;
                    idx_nxt   = 2'd0;
                end
            end
            ST_RESUME_TX: begin
                if (accept) begin
                    if (idx == seq_last(seq_mode)) state_nxt = ST_RUN;
                    else                           idx_nxt   = idx + 2'd1;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        char_valid  = 1'b0;
        send_xon    = 1'b0;
        fifo_stall  = 1'b0;
        flow_paused = 1'b0;
        unique case (state)
            ST_RUN: ;
            ST_HALT_TX: begin
                char_valid = 1'b1;
                fifo_stall = 1'b1;
            end
            ST_PAUSED: flow_paused = 1'b1;
            ST_RESUME_TX: begin
                char_valid  = 1'b1;
                send_xon    = 1'b1;
                fifo_stall  = 1'b1;
                flow_paused = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/xonxoff_tx_gen.sv
module xonxoff_tx_gen #(
    parameter int LVL_W      = 7,
    parameter int TRIG_W     = 4,
    parameter int TRIG_SCALE = 4,
    parameter int CHAR_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic [TRIG_W-1:0] halt_trig,
    input  logic [TRIG_W-1:0] resume_trig,
    input  logic [1:0]        tx_mode,
    input  logic [CHAR_W-1:0] xon1,
    input  logic [CHAR_W-1:0] xon2,
    input  logic [CHAR_W-1:0] xoff1,
    input  logic [CHAR_W-1:0] xoff2,
    input  logic [1:0]        word_len,
    input  logic              char_ready,
    output logic              char_valid,
    output logic [CHAR_W-1:0] char_data,
    output logic              fifo_stall,
    output logic              flow_paused
);
    localparam int SCALE_SH = $clog2(TRIG_SCALE);
    localparam int MIN_W    = CHAR_W - 3;

    logic       over_halt;
    logic       at_resume;
    logic       send_xon;
    logic [1:0] idx;
    logic [1:0] seq_mode;

    xf_trigger #(
        .LVL_W(LVL_W), .TRIG_W(TRIG_W), .SCALE_SH(SCALE_SH)
    ) u_trig (
        .fifo_level (fifo_level),
        .halt_trig  (halt_trig),
        .resume_trig(resume_trig),
        .over_halt  (over_halt),
        .at_resume  (at_resume)
    );

    xf_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_mode    (tx_mode),
        .over_halt  (over_halt),
        .at_resume  (at_resume),
        .char_ready (char_ready),
        .char_valid (char_valid),
        .send_xon   (send_xon),
        .idx        (idx),
        .seq_mode   (seq_mode),
        .fifo_stall (fifo_stall),
        .flow_paused(flow_paused)
    );

    xf_char_pick #(
        .CHAR_W(CHAR_W), .MIN_W(MIN_W)
    ) u_pick (
        .seq_mode (seq_mode),
        .send_xon (send_xon),
        .idx      (idx),
        .word_len (word_len),
        .xon1     (xon1),
        .xon2     (xon2),
        .xoff1    (xoff1),
        .xoff2    (xoff2),
        .char_data(char_data)
    );
endmodule

// File: rtl/xf_chk.sv
module xf_chk #(
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        tx_mode,
    input logic [1:0]        word_len,
    input logic              char_ready,
    input logic              char_valid,
    input logic [CHAR_W-1:0] char_data,
    input logic              fifo_stall,
    input logic              flow_paused
);
    logic [CHAR_W-1:0] wl_mask;
    assign wl_mask = {CHAR_W{1'b1}} >> (2'd3 - word_len);

    // R1
    always_comb begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!char_valid && !fifo_stall && !flow_paused);
        end
    end

    // R9
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && !char_ready) |=> (char_valid && $stable(char_data)));

    // R10
    stall_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |-> fifo_stall);

    // R8
    width_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |-> ((char_data & ~wl_mask) == '0));

    // R6
    idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_paused && !char_valid && tx_mode == 2'b00) |=> !char_valid);

    // R2
    pause_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flow_paused) |-> $past(char_valid && char_ready));

    // R3
    pause_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flow_paused) |-> $past(char_valid && char_ready));
endmodule

bind xonxoff_tx_gen xf_chk #(.CHAR_W(CHAR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_mode    (tx_mode),
    .word_len   (word_len),
    .char_ready (char_ready),
    .char_valid (char_valid),
    .char_data  (char_data),
    .fifo_stall (fifo_stall),
    .flow_paused(flow_paused)
);

// File: tb/sim_xonxoff_tx_gen.sv
`timescale 1ns/1ps
module sim_xonxoff_tx_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] fifo_level = '0;
    logic [3:0] halt_trig = '0;
    logic [3:0] resume_trig = '0;
    logic [1:0] tx_mode = '0;
    logic [7:0] xon1 = 8'h11, xon2 = 8'h91, xoff1 = 8'h13, xoff2 = 8'h93;
    logic [1:0] word_len = 2'b11;
    logic       char_ready = 1'b0;
    logic       char_valid;
    logic [7:0] char_data;
    logic       fifo_stall;
    logic       flow_paused;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    xonxoff_tx_gen u0 (
        .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level),
        .halt_trig(halt_trig), .resume_trig(resume_trig), .tx_mode(tx_mode),
        .xon1(xon1), .xon2(xon2), .xoff1(xoff1), .xoff2(xoff2),
        .word_len(word_len), .char_ready(char_ready), .char_valid(char_valid),
        .char_data(char_data), .fifo_stall(fifo_stall), .flow_paused(flow_paused)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_char(input logic [1:0] m, input bit is_xon,
                                            input int i, input logic [1:0] wl);
        logic [7:0] c;
        bit second;
        second = (m == 2'b01) || (m == 2'b11 && (i % 2) == 1);
        if (is_xon) c = second ? xon2 : xon1;
        else        c = second ? xoff2 : xoff1;
        case (wl)
            2'b00:   c = c & 8'h1F;
            2'b01:   c = c & 8'h3F;
            2'b10:   c = c & 8'h7F;
            default: c = c;
        endcase
        return c;
    endfunction

    // Collect one whole flow sequence with random back-pressure.
    task automatic run_seq(input logic [1:0] m, input bit is_xon, input int chg);
        int n;
        int w;
        int hold;
        logic [7:0] d0;
        logic [7:0] e;
        n = (m == 2'b11) ? 4 : 2;
        for (int i = 0; i < n; i++) begin
            w = 0;
            while (!char_valid && w < 50) begin
                @(negedge clk);
                w++;
            end
            chk(char_valid, is_xon ? "R3 offer" : "R2 offer", char_valid, 1);
            // R10
            chk(fifo_stall, "R10 stall", fifo_stall, 1);
            d0 = char_data;
            hold = $urandom_range(0, 2);
            for (int h = 0; h < hold; h++) begin
                @(negedge clk);
                // R9
                chk(char_valid && char_data == d0, "R9 hold", char_data, d0);
            end
            e = exp_char(m, is_xon, i, word_len);
            // R4 R5 R8 R12
            chk(char_data == e, (m == 2'b11) ? "R5 order" : "R4 char", char_data, e);
            char_ready = 1'b1;
            @(negedge clk);
            char_ready = 1'b0;
            if (i == 0 && chg >= 0) tx_mode = chg[1:0];
        end
    endtask

    task automatic quiet(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!char_valid, req, char_valid, 0);
        end
    endtask

    initial begin
        int hv;
        int rv;
        logic [1:0] m;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1
        chk(!char_valid && !fifo_stall && !flow_paused, "R1 reset",
            {char_valid, fifo_stall, flow_paused}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!char_valid && !fifo_stall && !flow_paused, "R1 after reset",
            {char_valid, fifo_stall, flow_paused}, 0);

        // R6: mode off, full FIFO
        halt_trig = 4'd8; resume_trig = 4'd4;
        tx_mode = 2'b00; fifo_level = 7'd64;
        quiet(6, "R6 off");

        // R11: exactly at the halt value
        tx_mode = 2'b10; fifo_level = 7'd32;
        quiet(5, "R11 halt edge");
        chk(!flow_paused, "R11 halt edge paused", flow_paused, 0);

        // R2 R4: set 1, 8-bit
        fifo_level = 7'd33;
        run_seq(2'b10, 1'b0, -1);
        chk(flow_paused, "R2 paused", flow_paused, 1);
        // R11: band inside
        fifo_level = 7'd17;
        quiet(5, "R11 band");
        chk(flow_paused, "R11 band paused", flow_paused, 1);
        // R3
        fifo_level = 7'd16;
        run_seq(2'b10, 1'b1, -1);
        chk(!flow_paused, "R3 running", flow_paused, 0);

        // R4 R8: set 2, 5-bit
        tx_mode = 2'b01; word_len = 2'b00;
        xoff2 = 8'hF3; xon2 = 8'hEE;
        fifo_level = 7'd60;
        run_seq(2'b01, 1'b0, -1);
        fifo_level = 7'd3;
        run_seq(2'b01, 1'b1, -1);

        // R5 R12: pair mode, mode changed mid-sequence
        tx_mode = 2'b11; word_len = 2'b10;
        xoff1 = 8'hC1; xoff2 = 8'hB2; xon1 = 8'hA3; xon2 = 8'h94;
        fifo_level = 7'd50;
        run_seq(2'b11, 1'b0, 2);
        chk(flow_paused, "R12 paused", flow_paused, 1);
        // R7: disable while paused, level still high
        tx_mode = 2'b00;
        run_seq(2'b11, 1'b1, -1);
        chk(!flow_paused, "R7 running", flow_paused, 0);
        quiet(4, "R6 off after R7");

        // Random mix
        for (int k = 0; k < 40; k++) begin
            m = 2'($urandom_range(1, 3));
            word_len = 2'($urandom_range(0, 3));
            xon1 = 8'($urandom); xon2 = 8'($urandom);
            xoff1 = 8'($urandom); xoff2 = 8'($urandom);
            hv = $urandom_range(2, 15);
            rv = $urandom_range(0, hv - 1);
            halt_trig = 4'(hv); resume_trig = 4'(rv);
            tx_mode = m;
            fifo_level = 7'(hv * 4);
            quiet(2, "R11 rnd halt edge");
            fifo_level = 7'(hv * 4 + 1 + $urandom_range(0, 3));
            run_seq(m, 1'b0, -1);
            chk(flow_paused, "R2 rnd paused", flow_paused, 1);
            fifo_level = 7'(rv * 4 + 1);
            quiet(2, "R11 rnd band");
            if ($urandom_range(0, 3) == 0) tx_mode = 2'b00;
            else fifo_level = 7'(rv * 4 - $urandom_range(0, rv * 4));
            run_seq(m, 1'b1, -1);
            chk(!flow_paused, "R3 rnd running", flow_paused, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule